// File: doc/BRIEF.md
# Receive Byte Queue with Fill Threshold and Idle Timeout

This block sits behind a serial receiver and holds up to 16 received bytes until the host fetches them. A byte stream enters through a valid/ready port, and the host takes bytes out through a plain read strobe with combinational data.

A fill counter is compared with a threshold picked by a 2-bit select. When a stored byte brings the fill up to the threshold, the block requests that the status bit "receive data full" be set. The block also raises a one-cycle receive interrupt request if interrupts are enabled. When a read brings the fill below the threshold, the block requests that the same bit be cleared.

When the fill stays below the threshold, an idle counter still wakes the host. It runs for 15 character times after the most recent stored byte. When it expires, it issues the same set and interrupt requests. The status bit itself is kept elsewhere. This block only emits the one-cycle set and clear requests.

Back-pressure rules for the input stream: `in_ready` follows `rx_en` and nothing else. While reception is enabled, every handshake completes. A byte handed over while all 16 entries are in use is discarded, and the queue does not change. While reception is disabled, no handshake completes.

Top module: `rx_trig_fifo`

## Requirements
- R1: After reset the queue is empty, `rd_data` reads 0, and `rdf_set`, `rdf_clr` and `rx_irq` are low.
- R2: Bytes leave through `rd_data`/`rd_en` in arrival order. The storage index wraps after the last of the 16 entries. `rd_data` shows the oldest byte, and a read strobe in a cycle removes it at that edge.
- R3: `in_ready` equals `rx_en`. A handshake that arrives while the queue holds 16 bytes is discarded, and the stored contents stay unchanged.
- R4: `trig_sel` 0, 1, 2 and 3 select thresholds of 1, 4, 8 and 14 bytes. A stored byte that leaves the fill at or above the threshold makes `rdf_set` high for the one cycle after that edge.
- R5: `rx_irq` pulses in exactly the cycles where `rdf_set` pulses, and only if `irq_en` was high at the causing edge.
- R6: A stored byte that leaves the fill below the threshold restarts the idle counter. Unless it is restarted or cancelled, the counter gives a one-cycle `rdf_set` (and `rx_irq` if enabled) 15×CHAR_CYCLES cycles after that edge.
- R7: A stored byte that reaches the threshold while `irq_en` is high cancels the idle counter. With `irq_en` low, a running counter is left running.
- R8: A read that leaves the fill below the threshold makes `rdf_clr` high for the one cycle after that edge.
- R9: A read strobe on an empty queue returns 0 and changes nothing.
- R10: `fifo_clr` empties the queue and stops the idle counter. The cycle after it shows no set, clear or interrupt request.
- R11: `rdf_set` and `rdf_clr` are never high together. When both would apply, set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_clr | input | 1 | Synchronous queue flush |
| rx_en | input | 1 | Reception enable |
| irq_en | input | 1 | Receive interrupt enable |
| trig_sel | input | 2 | Threshold select (1/4/8/14) |
| in_valid | input | 1 | Incoming byte valid |
| in_data | input | DW | Incoming byte |
| in_ready | output | 1 | Incoming byte accepted when high |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | DW | Oldest byte, 0 when empty |
| rdf_set | output | 1 | Request to set the data-full status bit |
| rdf_clr | output | 1 | Request to clear the data-full status bit |
| rx_irq | output | 1 | Receive interrupt request pulse |

## Verification
The bench builds the block with DEPTH 16 and CHAR_CYCLES 4, so a full idle timeout is 60 cycles. At that length, expiry, restart by spaced bytes and cancellation fit many times into a short run. The depth stays at 16 so that the threshold of 14 and the full-queue drop are both reached, along with the index wrap. Long random traffic with changing thresholds and enables follows the directed cases, and a behavioural queue model compares every output on every cycle.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef enum logic [1:0] {
    TRIG_1  = 2'd0,
    TRIG_4  = 2'd1,
    TRIG_8  = 2'd2,
    TRIG_14 = 2'd3
  } trig_sel_e;

  typedef struct packed {
    logic set;
    logic clr;
    logic irq;
  } rdf_evt_t;

  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (trig_sel_e'(sel))
      TRIG_1:  return 1;
      TRIG_4:  return 4;
      TRIG_8:  return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         push,
  input  logic                         pop,
  input  logic [DW-1:0]                wdata,
  output logic [DW-1:0]                rdata,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         push_ok,
  output logic                         pop_ok
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH+1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH-1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic [CW-1:0] cnt;

  assign push_ok = push && (cnt != FULL);
  assign pop_ok  = pop && (cnt != '0);
  assign rdata   = (cnt == '0) ? '0 : mem[rd_ptr];
  assign count   = cnt;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_cmp_wrap
      assign wr_nxt = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_nxt;
      if (pop_ok)  rd_ptr <= rd_nxt;
      if (push_ok && !pop_ok)      cnt <= cnt + 1'b1;
      else if (!push_ok && pop_ok) cnt <= cnt - 1'b1;
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);

  assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == FULL && push && !pop && !clr) |=> (cnt == FULL && wr_ptr == $past(wr_ptr)));

  assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && pop && !push && !clr) |=> (cnt == '0 && $stable(rd_ptr)));

endmodule

// File: rtl/rxf_timer.sv
module rxf_timer #(
  parameter int unsigned TMO = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic load,
  input  logic cancel,
  output logic expire
);
  localparam int unsigned TW = $clog2(TMO + 1);

  logic          running;
  logic [TW-1:0] tcnt;

  assign expire = running && (tcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      tcnt    <= '0;
    end else if (clr) begin
      running <= 1'b0;
      tcnt    <= '0;
    end else if (load) begin
      running <= 1'b1;
      tcnt    <= TW'(TMO - 1);
    end else if (cancel || expire) begin
      running <= 1'b0;
    end else if (running) begin
      tcnt <= tcnt - 1'b1;
    end
  end

  assert_single_expiry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !load) |=> !expire);

  assert_reload_delays_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((TMO > 1) && load && !clr) |=> !expire);

  assert_clr_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !expire);

endmodule

// File: rtl/rx_trig_fifo.sv
module rx_trig_fifo
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned DW          = 8,
  parameter int unsigned CHAR_CYCLES = 13021
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_clr,
  input  logic          rx_en,
  input  logic          irq_en,
  input  logic [1:0]    trig_sel,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rdf_set,
  output logic          rdf_clr,
  output logic          rx_irq
);
  localparam int unsigned TMO = 15 * CHAR_CYCLES;
  localparam int unsigned CW  = $clog2(DEPTH + 1);

  logic [CW-1:0] count;
  logic          push_ok, pop_ok, expire;
  logic [CW:0]   cnt_next, trig_lvl;
  logic          at_trig, below_push;
  rdf_evt_t      evt_d, evt_q;

  assign in_ready = rx_en;

  rxf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (fifo_clr),
    .push    (in_valid && rx_en),
    .pop     (rd_en),
    .wdata   (in_data),
    .rdata   (rd_data),
    .count   (count),
    .push_ok (push_ok),
    .pop_ok  (pop_ok)
  );

  assign trig_lvl   = (CW+1)'(trig_level(trig_sel));
  assign cnt_next   = {1'b0, count} + (CW+1)'(push_ok) - (CW+1)'(pop_ok);
  assign at_trig    = push_ok && (cnt_next >= trig_lvl);
  assign below_push = push_ok && (cnt_next < trig_lvl);

  rxf_timer #(.TMO(TMO)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (fifo_clr),
    .load   (below_push),
    .cancel (at_trig && irq_en),
    .expire (expire)
  );

  always_comb begin
    evt_d.set = at_trig || expire;
    evt_d.irq = evt_d.set && irq_en;
    evt_d.clr = pop_ok && (cnt_next < trig_lvl) && !evt_d.set;
    if (fifo_clr) evt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_d;
  end

  assign rdf_set = evt_q.set;
  assign rdf_clr = evt_q.clr;
  assign rx_irq  = evt_q.irq;

  assert_set_clr_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rdf_set && rdf_clr));

  assert_irq_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (rdf_set && $past(irq_en)));

  assert_clr_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (!rdf_set && !rdf_clr && !rx_irq));

  assert_trig_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (at_trig && !fifo_clr) |=> rdf_set);

  assert_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (at_trig && irq_en && !fifo_clr && !below_push) |=> !expire);

endmodule

// File: tb/rx_trig_fifo_tb.sv
module rx_trig_fifo_tb;
  localparam int CHAR = 4;
  localparam int TMO  = 15 * CHAR;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_clr = 1'b0, rx_en = 1'b1, irq_en = 1'b1;
  logic [1:0] trig_sel = 2'd0;
  logic       in_valid = 1'b0, rd_en = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, rdf_set, rdf_clr, rx_irq;
  logic [7:0] rd_data;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0, cmp_on = 1'b0;

  always #4 clk = ~clk;

  rx_trig_fifo #(.DEPTH(16), .DW(8), .CHAR_CYCLES(CHAR)) u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .rx_en(rx_en),
    .irq_en(irq_en), .trig_sel(trig_sel), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .rd_en(rd_en),
    .rd_data(rd_data), .rdf_set(rdf_set), .rdf_clr(rdf_clr), .rx_irq(rx_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  logic [7:0] q[$];
  bit e_set, e_clr, e_irq, trun;
  int tleft;

  function automatic int lvl(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); e_set = 0; e_clr = 0; e_irq = 0; trun = 0; tleft = 0;
    end else if (fifo_clr) begin
      q.delete(); e_set = 0; e_clr = 0; e_irq = 0; trun = 0;
    end else begin
      bit ex, pu, po, hit;
      int n;
      ex = trun && tleft == 0;
      pu = in_valid && rx_en && q.size() < 16;
      po = rd_en && q.size() > 0;
      if (po) void'(q.pop_front());
      if (pu) q.push_back(in_data);
      n = q.size();
      hit = pu && n >= lvl(trig_sel);
      e_set = hit || ex;
      e_irq = e_set && irq_en;
      e_clr = po && n < lvl(trig_sel) && !e_set;
      if (pu && !hit) begin trun = 1; tleft = TMO - 1; end
      else if (hit && irq_en) trun = 0;
      else if (ex) trun = 0;
      else if (trun) tleft--;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on && !done) begin
      int er;
      er = q.size() > 0 ? int'(q[0]) : 0;
      chk(rd_data == er[7:0], "R2 rd_data", rd_data, er);
      chk(in_ready == rx_en, "R3 in_ready", in_ready, rx_en);
      chk(rdf_set == e_set, "R4/R6 rdf_set", rdf_set, e_set);
      chk(rx_irq == e_irq, "R5 rx_irq", rx_irq, e_irq);
      chk(rdf_clr == e_clr, "R8 rdf_clr", rdf_clr, e_clr);
      chk(!(rdf_set && rdf_clr), "R11 exclusive", rdf_clr, 0);
    end
  end

  task automatic push(input logic [7:0] d);
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int n;
    bit seen;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
    chk(!rdf_set && !rdf_clr && !rx_irq, "R1 pulses", {rdf_set, rdf_clr, rx_irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_on = 1'b1;

    // R9 empty read
    pop();
    chk(rd_data == 8'h00, "R9 empty read", rd_data, 0);

    // R2/R3/R4 fill past full with threshold 14, wrap after drain
    trig_sel = 2'd3;
    for (int i = 0; i < 18; i++) push(8'(8'h30 + i));
    for (int i = 0; i < 17; i++) pop();
    for (int i = 0; i < 5; i++) push(8'(8'hA0 + i));
    for (int i = 0; i < 5; i++) pop();

    // R6 timeout length, threshold 4
    trig_sel = 2'd1;
    push(8'h55);
    n = 0;
    while (!rdf_set && n < 200) begin @(negedge clk); n++; end
    chk(n == TMO, "R6 timeout cycles", n, TMO);
    chk(rx_irq == 1'b1, "R5 timeout irq", rx_irq, 1);
    pop();

    // R6 restart by spaced bytes
    for (int i = 0; i < 3; i++) begin push(8'(i)); idle(TMO - 20); end
    idle(40);
    pop(); pop(); pop();

    // R7 cancel with irq_en, continue without
    irq_en = 1'b1; push(1); push(2); push(3); push(4);
    seen = 0;
    for (int i = 0; i < TMO + 10; i++) begin @(negedge clk); if (rdf_set) seen = 1; end
    chk(!seen, "R7 cancelled", seen, 0);
    for (int i = 0; i < 4; i++) pop();
    irq_en = 1'b0; push(5); push(6); push(7); push(8);
    idle(TMO + 10);
    for (int i = 0; i < 4; i++) pop();
    irq_en = 1'b1;

    // R3 rx disabled
    rx_en = 1'b0; push(8'hEE); rx_en = 1'b1;
    chk(rd_data == 8'h00, "R3 disabled push", rd_data, 0);

    // R10 flush
    push(8'h11); push(8'h22);
    fifo_clr = 1'b1; @(negedge clk); fifo_clr = 1'b0;
    chk(rd_data == 8'h00, "R10 flushed", rd_data, 0);
    seen = 0;
    for (int i = 0; i < TMO + 10; i++) begin @(negedge clk); if (rdf_set) seen = 1; end
    chk(!seen, "R10 timer stopped", seen, 0);

    // mixed traffic
    for (int i = 0; i < 4000; i++) begin
      in_valid = ($urandom % 3) == 0;
      in_data  = 8'($urandom);
      rd_en    = ($urandom % 4) == 0;
      if (($urandom % 200) == 0) trig_sel = 2'($urandom);
      if (($urandom % 300) == 0) irq_en = ~irq_en;
      if (($urandom % 500) == 0) rx_en = ~rx_en;
      fifo_clr = ($urandom % 900) == 0;
      @(negedge clk);
    end
    in_valid = 0; rd_en = 0; fifo_clr = 0;
    idle(TMO + 5);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule